// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a processor. It holds three registers: a pending-request register, an in-service register and a mask register. Priority is fixed. Line 0 ranks highest and line 7 lowest. The in-service register holds back any request that does not outrank the line already being served, so service nests in priority order.

The processor acknowledges with a falling edge on an active-low acknowledge pin. The controller then moves the winning line from pending to in-service and latches a vector. The vector equals a programmable base plus the line number times a spacing of 4 or 8. Software uses a small register bus with chip select, read, write and one address line. Through it, software sets the mask, the vector base, the trigger mode and the spacing. It also issues end-of-interrupt commands and reads back any of the three registers.

There is no streaming data path. All pins are plain control and status signals, so no valid/ready back-pressure applies.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset clears the pending, in-service and mask registers, the vector base and `vec_o`, and selects edge triggering, spacing 4 and pending-register readback. `int_o` is low after reset.
- R2: In edge mode, a low-to-high change of `irq_req[n]` sets pending bit n one clock later. The bit stays set if the line drops. A line held high is not latched again until it has been seen low.
- R3: In level mode, the pending register copies `irq_req` on each clock, one clock behind the pins.
- R4: Mask bit n = 1 keeps line n out of arbitration but does not stop it from being latched as pending. Masking one line leaves the other lines unaffected. A write with `a0`=1 loads the mask, where bit n masks line n.
- R5: `int_o` is high exactly when some unmasked pending line n exists whose index is lower than every set in-service bit.
- R6: On a falling edge of `inta_n` while `int_o` is high, the lowest-index unmasked pending line w is acknowledged. Its pending bit clears, its in-service bit sets, and `vec_o` becomes base + w × spacing (mod 256). All three changes are visible one clock later. `vec_o` holds its value until the next acknowledge.
- R7: On a falling edge of `inta_n` while `int_o` is low, the pending and in-service registers do not change, and `vec_o` becomes base + 7 × spacing.
- R8: An end-of-interrupt command clears only the lowest-index set in-service bit.
- R9: A write with `a0`=0 is a command, and `wdata[7:6]` selects its type. 00 sets the base to {`wdata[5:0]`,2'b00}. 01 is end-of-interrupt. 10 sets the mode: `wdata[0]`=1 selects level triggering and `wdata[1]`=1 selects spacing 8. 11 selects the status readback: `wdata[0]`=1 selects the in-service register, 0 the pending register.
- R10: With `cs_n` and `rd_n` low, `rdata` returns the mask when `a0`=1, or the selected status register when `a0`=0, in the same cycle. At all other times `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Request lines; bit 0 has the highest priority |
| inta_n | input | 1 | Active-low acknowledge; a falling edge starts an acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector latched by the last acknowledge |
| cs_n | input | 1 | Active-low register bus select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; each low cycle is one write |
| a0 | input | 1 | Address bit: 0 selects command/status, 1 selects mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
A request edge or level change on a pin reaches the pending register at the next clock, so `int_o` is due one cycle after the pins change. An acknowledge or end-of-interrupt takes effect at the clock that samples it, with `vec_o` and the registers showing the result at the following sample. Reads are combinational and are sampled within the cycle the strobe is low. The bench drives every input just after a falling clock edge and compares outputs at the next falling edge. In that cycle, a model updated at each rising edge has already taken the same registers' step, so each expectation lines up with the clock in which the requirement places the change.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;
  localparam int DW    = 8;

  typedef enum logic [1:0] {
    CMD_BASE = 2'b00,
    CMD_EOI  = 2'b01,
    CMD_MODE = 2'b10,
    CMD_RSEL = 2'b11
  } pic_cmd_e;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl_mode,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[g] <= 1'b0;
        pend[g] <= 1'b0;
      end else begin
        prev[g] <= irq_in[g];
        if (lvl_mode)
          pend[g] <= irq_in[g];
        else
          pend[g] <= (pend[g] & ~clr[g]) | (irq_in[g] & ~prev[g]);
      end
    end
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         a0,
  input  logic [W-1:0] wdata,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] insvc,
  output logic [N-1:0] mask,
  output logic [W-1:0] base,
  output logic         lvl_mode,
  output logic         step8,
  output logic         eoi_cmd,
  output logic [W-1:0] rdata
);
  logic     wr_en, rd_en, rsel_isr;
  pic_cmd_e cmd;

  assign wr_en   = !cs_n && !wr_n;
  assign rd_en   = !cs_n && !rd_n;
  assign cmd     = pic_cmd_e'(wdata[W-1:W-2]);
  assign eoi_cmd = wr_en && !a0 && (cmd == CMD_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask     <= '0;
      base     <= '0;
      lvl_mode <= 1'b0;
      step8    <= 1'b0;
      rsel_isr <= 1'b0;
    end else if (wr_en) begin
      if (a0) begin
        mask <= wdata[N-1:0];
      end else begin
        unique case (cmd)
          CMD_BASE: base     <= {wdata[W-3:0], 2'b00};
          CMD_MODE: begin
            lvl_mode <= wdata[0];
            step8    <= wdata[1];
          end
          CMD_RSEL: rsel_isr <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (a0)            rdata = W'(mask);
      else if (rsel_isr) rdata = W'(insvc);
      else               rdata = W'(pend);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N = LINES,
  parameter int W = DW,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_req,
  input  logic         inta_n,
  output logic         int_o,
  output logic [W-1:0] vec_o,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         a0,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  logic [N-1:0]  irr, isr, imr, ack_clr, eoi_clr;
  logic [W-1:0]  base;
  logic          lvl_mode, step8, eoi_cmd;
  logic          pend_hit, isr_hit, inta_q, ack_start, grant_ok;
  logic [IW-1:0] pend_idx, isr_idx, line;

  pic_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl_mode(lvl_mode),
    .irq_in(irq_req), .clr(ack_clr), .pend(irr)
  );

  pic_prio #(.N(N)) u_pick_pend (
    .req_vec(irr & ~imr), .hit(pend_hit), .idx(pend_idx)
  );

  pic_prio #(.N(N)) u_pick_isr (
    .req_vec(isr), .hit(isr_hit), .idx(isr_idx)
  );

  pic_regs #(.N(N), .W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a0(a0), .wdata(wdata), .pend(irr), .insvc(isr), .mask(imr),
    .base(base), .lvl_mode(lvl_mode), .step8(step8),
    .eoi_cmd(eoi_cmd), .rdata(rdata)
  );

  assign grant_ok  = pend_hit && (!isr_hit || (pend_idx < isr_idx));
  assign int_o     = grant_ok;
  assign ack_start = inta_q && !inta_n;
  assign ack_clr   = (ack_start && grant_ok) ? (N'(1) << pend_idx) : '0;
  assign eoi_clr   = (eoi_cmd && isr_hit) ? (N'(1) << isr_idx) : '0;
  assign line      = grant_ok ? pend_idx : IW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inta_q <= 1'b1;
      isr    <= '0;
      vec_o  <= '0;
    end else begin
      inta_q <= inta_n;
      isr    <= (isr & ~eoi_clr) | ack_clr;
      if (ack_start)
        vec_o <= base + (W'(line) << (step8 ? 3 : 2));
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N = 8,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inta_n,
  input logic         int_o,
  input logic [W-1:0] vec_o,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] imr,
  input logic         eoi_cmd
);
  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) int_o |-> ((irr & ~imr) != '0)); // R5
  AST_ACK_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(inta_n) && int_o) |=> ($countones(isr & ~$past(isr)) == 1)); // R6
  AST_ACK_SKIPS_MASKED: assert property (@(posedge clk) disable iff (!rst_n) ($fell(inta_n) && int_o) |=> (((isr & ~$past(isr)) & $past(imr)) == '0)); // R4
  AST_NO_GRANT_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n) !($fell(inta_n) && int_o) |=> ((isr & ~$past(isr)) == '0)); // R7
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n) (eoi_cmd && (isr != '0) && !($fell(inta_n) && int_o)) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8
  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !$fell(inta_n) |=> $stable(vec_o)); // R6
endmodule

bind prio_irq_ctrl pic_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .int_o(int_o), .vec_o(vec_o),
  .irr(irr), .isr(isr), .imr(imr), .eoi_cmd(eoi_cmd)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [7:0] irq_req = 0, wdata = 0;
  logic       inta_n = 1, cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0;
  logic       int_o;
  logic [7:0] vec_o, rdata, v;
  int         n_chk = 0, n_fail = 0;
  bit         chk_on = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .inta_n(inta_n),
    .int_o(int_o), .vec_o(vec_o), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a0(a0), .wdata(wdata), .rdata(rdata)
  );

  always #4 clk = ~clk;

  // Reference model built from the requirements
  logic [7:0] m_irr, m_isr, m_imr, m_prev, m_base, m_vec;
  logic       m_lvl, m_step8, m_inta_q;

  function automatic int low8(logic [7:0] x);
    for (int i = 0; i < 8; i++) if (x[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    return low8(m_irr & ~m_imr) < low8(m_isr);
  endfunction

  always @(posedge clk) begin : model
    int p, s;
    logic g, ack;
    logic [7:0] clr, setb, eclr;
    if (!rst_n) begin
      m_irr <= 0; m_isr <= 0; m_imr <= 0; m_prev <= 0; m_base <= 0;
      m_vec <= 0; m_lvl <= 0; m_step8 <= 0; m_inta_q <= 1;
    end else begin
      p    = low8(m_irr & ~m_imr);
      s    = low8(m_isr);
      g    = (p < s);
      ack  = m_inta_q && !inta_n;
      setb = (ack && g) ? 8'(1 << p) : 8'h00;
      clr  = setb;
      eclr = (!cs_n && !wr_n && !a0 && wdata[7:6] == 2'b01 && s < 8) ? 8'(1 << s) : 8'h00;
      m_inta_q <= inta_n;
      m_prev   <= irq_req;
      m_irr    <= m_lvl ? irq_req : ((m_irr & ~clr) | (irq_req & ~m_prev));
      m_isr    <= (m_isr & ~eclr) | setb;
      if (ack) m_vec <= m_base + 8'((g ? p : 7) * (m_step8 ? 8 : 4));
      if (!cs_n && !wr_n) begin
        if (a0) m_imr <= wdata;
        else if (wdata[7:6] == 2'b00) m_base <= {wdata[5:0], 2'b00};
        else if (wdata[7:6] == 2'b10) begin m_lvl <= wdata[0]; m_step8 <= wdata[1]; end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && chk_on) begin
    chk(8'(int_o), 8'(exp_int()), "R5 int_o vs model");
    chk(vec_o, m_vec, "R6 vec_o vs model");
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = a;
    #2 d = rdata;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic ack();
    @(negedge clk); inta_n = 0;
    @(negedge clk); inta_n = 1;
  endtask

  task automatic rd_isr(output logic [7:0] d);
    wr(0, 8'hC1); rd(0, d); wr(0, 8'hC0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    // R1 / R10: reset state and readback paths
    @(negedge clk);
    chk(8'(int_o), 8'h00, "R1 int_o after reset");
    chk(vec_o, 8'h00, "R1 vec_o after reset");
    rd(0, v); chk(v, 8'h00, "R1 pending after reset");
    rd(1, v); chk(v, 8'h00, "R1 mask after reset");
    rd_isr(v); chk(v, 8'h00, "R1 in-service after reset");
    #2 chk(rdata, 8'h00, "R10 rdata idle");
    // R2: edge latch, no relatch while held high
    @(negedge clk); irq_req[5] = 1;
    @(negedge clk); chk(8'(int_o), 8'h01, "R2 edge latched");
    rd(0, v); chk(v, 8'h20, "R10 pending readback");
    ack(); chk(vec_o, 8'd20, "R6 vector line5 spacing4");
    rd(0, v); chk(v, 8'h00, "R6 pending cleared on ack");
    rd_isr(v); chk(v, 8'h20, "R6 in-service set on ack");
    repeat (3) @(negedge clk);
    rd(0, v); chk(v, 8'h00, "R2 held line not relatched");
    // R5 / R8: nesting
    @(negedge clk); irq_req[2] = 1;
    @(negedge clk); chk(8'(int_o), 8'h01, "R5 higher line preempts");
    ack(); chk(vec_o, 8'd8, "R6 vector line2");
    @(negedge clk); irq_req[6] = 1;
    @(negedge clk); chk(8'(int_o), 8'h00, "R5 lower line blocked");
    wr(0, 8'h40); rd_isr(v); chk(v, 8'h20, "R8 eoi clears lowest bit");
    chk(8'(int_o), 8'h00, "R5 still blocked by line5");
    wr(0, 8'h40); rd_isr(v); chk(v, 8'h00, "R8 second eoi");
    chk(8'(int_o), 8'h01, "R5 line6 released");
    ack(); chk(vec_o, 8'd24, "R6 vector line6");
    wr(0, 8'h40);
    // R4: masking
    @(negedge clk); irq_req = 0;
    wr(1, 8'h01);
    @(negedge clk); irq_req = 8'h11;
    @(negedge clk); chk(8'(int_o), 8'h01, "R4 unmasked line4 raises");
    ack(); chk(vec_o, 8'd16, "R4 masked line0 skipped");
    wr(0, 8'h40);
    rd(0, v); chk(v, 8'h01, "R4 masked line still pending");
    chk(8'(int_o), 8'h00, "R4 masked line no int");
    wr(1, 8'h00);
    @(negedge clk); chk(8'(int_o), 8'h01, "R4 unmask raises");
    ack(); chk(vec_o, 8'd0, "R6 vector line0");
    wr(0, 8'h40);
    // R9 / R7: base, spacing, spurious acknowledge
    wr(0, 8'h82); wr(0, 8'h10);
    ack(); chk(vec_o, 8'h78, "R7 spurious vector base+7*8");
    rd_isr(v); chk(v, 8'h00, "R7 spurious leaves in-service");
    // R3: level mode
    @(negedge clk); irq_req = 0;
    wr(0, 8'h83);
    @(negedge clk); irq_req[1] = 1;
    @(negedge clk); chk(8'(int_o), 8'h01, "R3 level raises");
    irq_req[1] = 0;
    @(negedge clk); chk(8'(int_o), 8'h00, "R3 level follows pin");
    rd(0, v); chk(v, 8'h00, "R3 pending follows pin");
    // Random phase, checked every cycle against the model
    wr(0, 8'h80);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      cs_n = 1; wr_n = 1;
      if ($urandom_range(3) == 0) irq_req = irq_req ^ 8'(1 << $urandom_range(7));
      inta_n = ($urandom_range(5) == 0) ? 1'b0 : 1'b1;
      case ($urandom_range(11))
        0: begin cs_n = 0; wr_n = 0; a0 = 0; wdata = 8'h40; end
        1: begin cs_n = 0; wr_n = 0; a0 = 1; wdata = 8'($urandom) & 8'($urandom); end
        2: begin cs_n = 0; wr_n = 0; a0 = 0; wdata = {6'b100000, 2'($urandom)}; end
        3: begin cs_n = 0; wr_n = 0; a0 = 0; wdata = {2'b00, 6'($urandom)}; end
        default: ;
      endcase
    end
    @(negedge clk); cs_n = 1; wr_n = 1; inta_n = 1;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule